// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Pinned Slots

This block is a small, fully associative cache of virtual-to-physical page translations. Every slot holds a virtual page number, an address-space tag, a physical frame number, a two-bit permission code and a flag that lets the slot answer for every address space. A lookup compares the presented page number and address-space tag against all slots at once. In the same cycle it returns the frame number, the permission code and a fault flag when the requested kind of access is not allowed. Because slots carry the address-space tag, a context switch needs no invalidation.

After a miss, the surrounding logic walks the page table and then loads the result through the fill port. The slot that a fill overwrites comes from a round-robin pointer that skips pinned ("wired") slots, so pinned translations stay resident for as long as they are pinned. A slot is pinned or released by index through a separate control. Invalidation comes in two forms: one clears the whole cache, the other clears only the unpinned, non-global slots that belong to one address space. When every slot is pinned, a fill cannot be placed: it is dropped and an error pulse is raised.

Top module: `asid_tlb`

## Requirements
- R1: After reset no slot is valid, no slot is pinned and the replacement pointer is 0, so every lookup misses.
- R2: `lk_hit` is high, in the same cycle as `lk_valid`, only when some valid slot holds `lk_vpn` and either holds `lk_asid` or has its global flag set. On a hit, `lk_pfn` and `lk_perm` give that slot's contents. `lk_hit` is low whenever `lk_valid` is low.
- R3: Permission codes are 0 read-only, 1 read-write, 2 execute-only and 3 no access. Access kinds are 0 load, 1 store, 2 instruction fetch and 3 reserved. Read-only allows load, read-write allows load and store, and execute-only allows fetch. `lk_fault` is high on a hit whose kind is not allowed, and it is never high without a hit.
- R4: An accepted fill writes its entry at the next rising edge, and the entry is visible to lookups from that cycle on.
- R5: A fill goes to the first unpinned slot found by scanning upward from the replacement pointer, wrapping past the last slot. The pointer then moves to the slot after the one filled, wrapping to 0.
- R6: `wire_valid` with `wire_set` = 1 pins slot `wire_idx`, and with `wire_set` = 0 releases it, from the next edge. A pinned slot is never overwritten by a fill.
- R7: When every slot is pinned, a fill changes no slot and `fill_err` is high for exactly the one cycle after it.
- R8: `flush_all` clears the valid and pinned state of every slot at the next edge.
- R9: `flush_by_asid` clears, at the next edge, every slot tagged `flush_asid_id` that is neither pinned nor global. All other slots are kept.
- R10: When several commands arrive in one cycle, only the first of this order takes effect: `flush_all`, `flush_by_asid`, fill, pin/release.
- R11: When more than one slot matches a lookup, the lowest-numbered matching slot supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Address-space tag of the request |
| lk_kind | input | 2 | Access kind (0 load, 1 store, 2 fetch, 3 reserved) |
| lk_hit | output | 1 | A slot matched |
| lk_pfn | output | PFN_W | Frame number of the matching slot |
| lk_perm | output | 2 | Permission code of the matching slot |
| lk_fault | output | 1 | Hit whose access kind is not allowed |
| fill_valid | input | 1 | Fill command |
| fill_vpn | input | VPN_W | Page number to store |
| fill_asid | input | ASID_W | Address-space tag to store |
| fill_pfn | input | PFN_W | Frame number to store |
| fill_perm | input | 2 | Permission code to store |
| fill_global | input | 1 | Slot matches every address space |
| fill_err | output | 1 | Pulse: the previous fill found no unpinned slot |
| flush_all | input | 1 | Invalidate and release every slot |
| flush_by_asid | input | 1 | Invalidate one address space |
| flush_asid_id | input | ASID_W | Address space to invalidate |
| wire_valid | input | 1 | Pin/release command |
| wire_set | input | 1 | 1 pins, 0 releases |
| wire_idx | input | IDX_W | Slot to pin or release |

## Verification
The bench builds the block with 8 slots, 12-bit page numbers, 10-bit frame numbers and 4-bit address-space tags. With 8 slots, a few fills are enough to wrap the replacement pointer and evict an older translation, and pinning all eight slots to force a rejected fill takes only a handful of commands. The narrow tags make it cheap to set up duplicate matches between a global slot and a tagged one, and to run address-space invalidation over a cache full of several address spaces.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    PERM_RO   = 2'd0,
    PERM_RW   = 2'd1,
    PERM_XO   = 2'd2,
    PERM_NONE = 2'd3
  } perm_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  // Whether an access kind is allowed under a permission code
  function automatic logic access_ok(input logic [1:0] perm, input logic [1:0] kind);
    logic ok;
    case (perm)
      PERM_RO: ok = (kind == ACC_LOAD);
      PERM_RW: ok = (kind == ACC_LOAD) || (kind == ACC_STORE);
      PERM_XO: ok = (kind == ACC_FETCH);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]      valid,
  input  logic [N-1:0]      glob,
  input  logic [VPN_W-1:0]  vpn_tab  [N],
  input  logic [ASID_W-1:0] asid_tab [N],
  input  logic [VPN_W-1:0]  key_vpn,
  input  logic [ASID_W-1:0] key_asid,
  output logic              hit_any,
  output logic [IDX_W-1:0]  hit_idx
);

  logic [N-1:0] hit_vec;

  // One comparator per slot, all evaluated in parallel
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec[i] = valid[i] && (vpn_tab[i] == key_vpn) &&
                        (glob[i] || (asid_tab[i] == key_asid));
  end

  assign hit_any = |hit_vec;

  // Lowest-numbered match wins
  always_comb begin
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  always_comb begin
    // R11
    if (hit_any) idx_points_at_match_chk: assert (hit_vec[hit_idx]);
  end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     wired,
  input  logic [IDX_W-1:0] ptr,
  output logic [IDX_W-1:0] victim,
  output logic             found
);

  // First unpinned slot at or after ptr, wrapping
  always_comb begin
    victim = '0;
    found  = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      int idx;
      idx = int'(ptr) + k;
      if (idx >= N) idx = idx - N;
      if (!wired[idx]) begin
        victim = IDX_W'(idx);
        found  = 1'b1;
      end
    end
  end

  always_comb begin
    // R6
    if (found) victim_unpinned_chk: assert (!wired[victim]);
  end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [1:0]        lk_kind,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [1:0]        lk_perm,
  output logic              lk_fault,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [1:0]        fill_perm,
  input  logic              fill_global,
  output logic              fill_err,
  input  logic              flush_all,
  input  logic              flush_by_asid,
  input  logic [ASID_W-1:0] flush_asid_id,
  input  logic              wire_valid,
  input  logic              wire_set,
  input  logic [IDX_W-1:0]  wire_idx
);

  // Slot contents (no reset needed: guarded by valid_q)
  logic [VPN_W-1:0]  vpn_q  [ENTRIES];
  logic [ASID_W-1:0] asid_q [ENTRIES];
  logic [PFN_W-1:0]  pfn_q  [ENTRIES];
  logic [1:0]        perm_q [ENTRIES];
  logic [ENTRIES-1:0] glob_q;

  // Control state
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [ENTRIES-1:0] wired_q, wired_d;
  logic [IDX_W-1:0]   ptr_q, ptr_d;
  logic               err_q, err_d;

  logic               lk_any;
  logic [IDX_W-1:0]   lk_idx;
  logic [IDX_W-1:0]   victim;
  logic               victim_found;

  logic cmd_fill, cmd_wire, cmd_fasid, fill_go;

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
    .valid    (valid_q),
    .glob     (glob_q),
    .vpn_tab  (vpn_q),
    .asid_tab (asid_q),
    .key_vpn  (lk_vpn),
    .key_asid (lk_asid),
    .hit_any  (lk_any),
    .hit_idx  (lk_idx)
  );

  tlb_victim #(.N(ENTRIES)) u_victim (
    .wired  (wired_q),
    .ptr    (ptr_q),
    .victim (victim),
    .found  (victim_found)
  );

  // Lookup result
  always_comb begin
    lk_hit   = lk_valid && lk_any;
    lk_pfn   = lk_hit ? pfn_q[lk_idx]  : '0;
    lk_perm  = lk_hit ? perm_q[lk_idx] : '0;
    lk_fault = lk_hit && !tlb_pkg::access_ok(perm_q[lk_idx], lk_kind);
  end

  // Command priority: flush_all > flush_by_asid > fill > wire
  always_comb begin
    cmd_fasid = !flush_all && flush_by_asid;
    cmd_fill  = !flush_all && !flush_by_asid && fill_valid;
    cmd_wire  = !flush_all && !flush_by_asid && !fill_valid && wire_valid;
    fill_go   = cmd_fill && victim_found;
  end

  // Next state
  always_comb begin
    valid_d = valid_q;
    wired_d = wired_q;
    ptr_d   = ptr_q;
    err_d   = cmd_fill && !victim_found;
    if (flush_all) begin
      valid_d = '0;
      wired_d = '0;
    end else if (cmd_fasid) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if ((asid_q[i] == flush_asid_id) && !wired_q[i] && !glob_q[i])
          valid_d[i] = 1'b0;
      end
    end else if (fill_go) begin
      valid_d[victim] = 1'b1;
      ptr_d = (int'(victim) == ENTRIES - 1) ? '0 : victim + 1'b1;
    end else if (cmd_wire && (int'(wire_idx) < ENTRIES)) begin
      wired_d[wire_idx] = wire_set;
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      wired_q <= '0;
      ptr_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      wired_q <= wired_d;
      ptr_q   <= ptr_d;
      err_q   <= err_d;
    end
  end

  // Slot data, written only by an accepted fill
  always_ff @(posedge clk) begin
    if (fill_go) begin
      vpn_q[victim]  <= fill_vpn;
      asid_q[victim] <= fill_asid;
      pfn_q[victim]  <= fill_pfn;
      perm_q[victim] <= fill_perm;
      glob_q[victim] <= fill_global;
    end
  end

  assign fill_err = err_q;

  // R6
  fill_keeps_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush_all && !flush_by_asid) |=> $stable(wired_q));

  // R7
  reject_keeps_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_err |-> $stable(valid_q));

  // R8
  flush_clears_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_q == '0) && (wired_q == '0));

  // R3
  fault_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit);

endmodule

// File: tb/tb_asid_tlb.sv
module tb_asid_tlb;

  localparam int CLK_PERIOD = 10;
  localparam int N      = 8;
  localparam int VPN_W  = 12;
  localparam int PFN_W  = 10;
  localparam int ASID_W = 4;
  localparam int IDX_W  = $clog2(N);

  logic clk, rst_n;
  logic lk_valid; logic [VPN_W-1:0] lk_vpn; logic [ASID_W-1:0] lk_asid; logic [1:0] lk_kind;
  logic lk_hit; logic [PFN_W-1:0] lk_pfn; logic [1:0] lk_perm; logic lk_fault;
  logic fill_valid; logic [VPN_W-1:0] fill_vpn; logic [ASID_W-1:0] fill_asid;
  logic [PFN_W-1:0] fill_pfn; logic [1:0] fill_perm; logic fill_global; logic fill_err;
  logic flush_all, flush_by_asid; logic [ASID_W-1:0] flush_asid_id;
  logic wire_valid, wire_set; logic [IDX_W-1:0] wire_idx;

  int checks = 0;
  int failures = 0;

  // Reference model of the slots
  logic [VPN_W-1:0]  m_vpn  [N];
  logic [ASID_W-1:0] m_asid [N];
  logic [PFN_W-1:0]  m_pfn  [N];
  logic [1:0]        m_perm [N];
  logic              m_glob [N];
  logic              m_val  [N];
  logic              m_wir  [N];
  int                m_ptr;

  logic r_hit, r_fault, r_err;
  logic [PFN_W-1:0] r_pfn;

  asid_tlb #(.ENTRIES(N), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) dut (
    .clk, .rst_n, .lk_valid, .lk_vpn, .lk_asid, .lk_kind, .lk_hit, .lk_pfn, .lk_perm,
    .lk_fault, .fill_valid, .fill_vpn, .fill_asid, .fill_pfn, .fill_perm, .fill_global,
    .fill_err, .flush_all, .flush_by_asid, .flush_asid_id, .wire_valid, .wire_set, .wire_idx
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic allowed(input logic [1:0] perm, input logic [1:0] kind);
    if (perm == 2'd0) return kind == 2'd0;
    if (perm == 2'd1) return kind == 2'd0 || kind == 2'd1;
    if (perm == 2'd2) return kind == 2'd2;
    return 1'b0;
  endfunction

  // Issue one cycle of commands and update the model by the priority rule
  task automatic cmd(input logic fa, input logic fb, input logic [ASID_W-1:0] fid,
                     input logic fv, input int v, input int a, input int p,
                     input int pm, input logic g,
                     input logic wv, input logic ws, input int wi);
    @(negedge clk);
    flush_all = fa; flush_by_asid = fb; flush_asid_id = fid;
    fill_valid = fv; fill_vpn = VPN_W'(v); fill_asid = ASID_W'(a);
    fill_pfn = PFN_W'(p); fill_perm = 2'(pm); fill_global = g;
    wire_valid = wv; wire_set = ws; wire_idx = IDX_W'(wi);
    @(negedge clk);
    r_err = fill_err;
    flush_all = 0; flush_by_asid = 0; fill_valid = 0; wire_valid = 0;
    if (fa) begin
      for (int i = 0; i < N; i++) begin m_val[i] = 0; m_wir[i] = 0; end
    end else if (fb) begin
      for (int i = 0; i < N; i++)
        if (m_asid[i] == fid && !m_wir[i] && !m_glob[i]) m_val[i] = 0;
    end else if (fv) begin
      int vic;
      vic = -1;
      for (int k = N - 1; k >= 0; k--)
        if (!m_wir[(m_ptr + k) % N]) vic = (m_ptr + k) % N;
      if (vic >= 0) begin
        m_vpn[vic] = VPN_W'(v); m_asid[vic] = ASID_W'(a); m_pfn[vic] = PFN_W'(p);
        m_perm[vic] = 2'(pm); m_glob[vic] = g; m_val[vic] = 1;
        m_ptr = (vic + 1) % N;
      end
    end else if (wv) begin
      m_wir[wi] = ws;
    end
  endtask

  task automatic fill(input int v, input int a, input int p, input int pm, input logic g);
    cmd(0, 0, '0, 1, v, a, p, pm, g, 0, 0, 0);
  endtask

  task automatic pin(input int idx, input logic s);
    cmd(0, 0, '0, 0, 0, 0, 0, 0, 0, 1, s, idx);
  endtask

  // Lookup compared against the model
  task automatic look(input string req, input int v, input int a, input int k);
    logic eh, ef; logic [PFN_W-1:0] ep;
    eh = 0; ef = 0; ep = '0;
    for (int i = N - 1; i >= 0; i--)
      if (m_val[i] && m_vpn[i] == VPN_W'(v) && (m_glob[i] || m_asid[i] == ASID_W'(a))) begin
        eh = 1; ep = m_pfn[i]; ef = !allowed(m_perm[i], 2'(k));
      end
    @(negedge clk);
    lk_valid = 1; lk_vpn = VPN_W'(v); lk_asid = ASID_W'(a); lk_kind = 2'(k);
    #1;
    r_hit = lk_hit; r_pfn = lk_pfn; r_fault = lk_fault;
    lk_valid = 0;
    chk(req, "hit", 32'(r_hit), 32'(eh));
    chk(req, "pfn", 32'(r_pfn), 32'(ep));
    chk(req, "fault", 32'(r_fault), 32'(ef));
  endtask

  task automatic t_reset;
    for (int i = 0; i < N; i++) begin m_val[i] = 0; m_wir[i] = 0; m_glob[i] = 0; m_asid[i] = '0; end
    m_ptr = 0;
    look("R1", 'h000, 0, 0);
    chk("R1", "fill_err after reset", 32'(fill_err), 0);
    look("R2", 'h000, 0, 0);
    chk("R2", "hit with lk_valid low", 32'(lk_hit), 0);
  endtask

  task automatic t_basic;
    fill('h010, 1, 'h101, 1, 0);
    look("R4", 'h010, 1, 0);
    chk("R4", "fill visible", 32'(r_hit), 1);
    fill('h011, 1, 'h102, 1, 0);
    fill('h012, 1, 'h103, 1, 0);
    look("R2", 'h011, 1, 1);
    look("R2", 'h011, 2, 0);
    chk("R2", "other asid misses", 32'(r_hit), 0);
    look("R2", 'h013, 1, 0);
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 6; i++) fill('h020 + i, 1, 'h200 + i, 1, 0);
    look("R5", 'h010, 1, 0);
    chk("R5", "oldest evicted", 32'(r_hit), 0);
    look("R5", 'h011, 1, 0);
    chk("R5", "next kept", 32'(r_hit), 1);
    fill('h028, 1, 'h208, 1, 0);
    look("R5", 'h011, 1, 0);
    chk("R5", "second eviction", 32'(r_hit), 0);
  endtask

  task automatic t_global;
    fill('h030, 5, 'h300, 0, 1);
    look("R2", 'h030, 9, 0);
    chk("R2", "global any asid", 32'(r_hit), 1);
    look("R2", 'h030, 5, 0);
  endtask

  task automatic t_perm;
    for (int p = 0; p < 4; p++) fill('h040 + p, 2, 'h040 + p, p, 0);
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 4; k++) look("R3", 'h040 + p, 2, k);
    look("R3", 'h041, 3, 1);
    chk("R3", "no fault on miss", 32'(r_fault), 0);
  endtask

  task automatic t_pin;
    pin(0, 1);
    pin(3, 1);
    for (int i = 0; i < 8; i++) fill('h050 + i, 3, 'h150 + i, 1, 0);
    look("R6", int'(m_vpn[0]), int'(m_asid[0]), 0);
    chk("R6", "pinned slot 0 kept", 32'(r_hit), 1);
    look("R6", int'(m_vpn[3]), int'(m_asid[3]), 0);
    chk("R6", "pinned slot 3 kept", 32'(r_hit), 1);
    for (int i = 0; i < 8; i++) look("R6", 'h050 + i, 3, 0);
  endtask

  task automatic t_allpinned;
    for (int i = 0; i < N; i++) pin(i, 1);
    fill('h060, 4, 'h360, 1, 0);
    chk("R7", "fill_err pulse", 32'(r_err), 1);
    look("R7", 'h060, 4, 0);
    chk("R7", "rejected fill absent", 32'(r_hit), 0);
    chk("R7", "fill_err one cycle", 32'(fill_err), 0);
    for (int i = 0; i < 8; i++) look("R7", 'h050 + i, 3, 0);
  endtask

  task automatic t_flush_asid;
    for (int i = 0; i < N; i++) pin(i, 0);
    fill('h070, 3, 'h370, 1, 1);
    pin(int'(m_ptr), 1);
    cmd(0, 1, 4'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    look("R9", 'h070, 3, 0);
    chk("R9", "global kept", 32'(r_hit), 1);
    for (int i = 0; i < 8; i++) look("R9", 'h050 + i, 3, 0);
    look("R9", 'h040, 2, 0);
  endtask

  task automatic t_flush_all;
    pin(2, 1);
    cmd(1, 0, '0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    look("R8", 'h070, 3, 0);
    chk("R8", "all invalid", 32'(r_hit), 0);
    for (int i = 0; i < 8; i++) fill('h080 + i, 6, 'h180 + i, 1, 0);
    for (int i = 0; i < 8; i++) begin
      look("R8", 'h080 + i, 6, 0);
      chk("R8", "pin released, all 8 resident", 32'(r_hit), 1);
    end
  endtask

  task automatic t_priority;
    cmd(1, 0, '0, 1, 'h0A0, 7, 'h0A0, 1, 0, 0, 0, 0);
    look("R10", 'h0A0, 7, 0);
    chk("R10", "fill under flush_all dropped", 32'(r_hit), 0);
    fill('h0A1, 7, 'h0A1, 1, 0);
    cmd(0, 1, 4'd5, 1, 'h0A2, 7, 'h0A2, 1, 0, 0, 0, 0);
    look("R10", 'h0A2, 7, 0);
    chk("R10", "fill under asid flush dropped", 32'(r_hit), 0);
    look("R10", 'h0A1, 7, 0);
    cmd(0, 0, '0, 1, 'h0A3, 7, 'h0A3, 1, 0, 1, 1, int'(m_ptr));
    for (int i = 0; i < 8; i++) fill('h0B0 + i, 7, 'h0B0 + i, 1, 0);
    look("R10", 'h0A3, 7, 0);
    chk("R10", "pin under fill dropped", 32'(r_hit), 0);
  endtask

  task automatic t_dup;
    cmd(1, 0, '0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    fill('h090, 1, 'h011, 1, 0);
    fill('h090, 2, 'h022, 1, 1);
    look("R11", 'h090, 1, 0);
    chk("R11", "both resident", 32'(r_hit), 1);
    look("R11", 'h090, 9, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0;
    lk_valid = 0; lk_vpn = '0; lk_asid = '0; lk_kind = '0;
    fill_valid = 0; fill_vpn = '0; fill_asid = '0; fill_pfn = '0; fill_perm = '0; fill_global = 0;
    flush_all = 0; flush_by_asid = 0; flush_asid_id = '0;
    wire_valid = 0; wire_set = 0; wire_idx = '0;
    r_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_basic;
    t_wrap;
    t_global;
    t_perm;
    t_pin;
    t_allpinned;
    t_flush_asid;
    t_flush_all;
    t_priority;
    t_dup;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule